// File: doc/BRIEF.md
# Auto-Modify Operand Address Sequencer

This block issues the address for one operand transfer at a time when a floating-point or wide-operand instruction reaches memory through an address register. For each request it takes the addressing class, the register index and that register's current value, an already computed base address for displacement, indexed and absolute forms, and the operand size. It returns the access address, a write-back of the modified register for the self-updating classes, and an error flag for combinations that cannot be carried out.

Wide operands are often moved in several parts to a fixed address. For the classes that do not modify a register, the block keeps a running byte offset, so repeated parts land at consecutive locations. A clear input, pulsed at the start of each instruction, zeroes that offset. Sub-word operands kept in 32-bit registers sit in the low-order bytes, and the block reports the byte lane at which the operand starts. The data itself is moved elsewhere.

Each response is registered and appears one clock after its request. The register write-back leaves in the same cycle as the address, through a single write port.

Top module: `ea_autoupdate`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_err` and `rsp_wb_en` are low.
- R2: Size codes 0,1,2,3,4 mean 1, 2, 4, 8 and 12 bytes. The register step equals the size in bytes. The one exception is a 1-byte access through register 15, the stack pointer, which steps by 2.
- R3: Predecrement (mode 3): the address is the register value minus the step. The same value is written back to the same register, and the running offset becomes zero.
- R4: Postincrement (mode 2): the address is the unmodified register value. The register is written back as the value plus the step, and the running offset becomes zero.
- R5: Register-indirect (mode 1) addresses register value plus offset. Base (mode 4) addresses `req_base` plus offset. Neither writes back, and each grows the offset by the size in bytes, not by the step.
- R6: A request with `req_pc_rel` high in mode 2 or mode 3 is an error.
- R7: Register direct (mode 0) gives address 0 and no write-back, and grows the offset by the size in bytes. It is an error if the size exceeds 4 bytes or if the offset is nonzero, which makes a second direct transfer illegal.
- R8: `rsp_lane` is 3 for 1-byte operands, 2 for 2-byte operands and 0 for all other sizes.
- R9: Mode codes 5 to 7 and size codes 5 to 7 are errors. An errored request raises `rsp_err`, writes nothing back and leaves the offset unchanged.
- R10: `clr_ofs` zeroes the offset. A request in the same cycle already sees an offset of zero.
- R11: Every request yields exactly one response in the next cycle, and `rsp_valid` is low in every cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_ofs | input | 1 | Zero the running offset (start of instruction) |
| req_valid | input | 1 | Transfer request |
| req_mode | input | 3 | Addressing class code |
| req_pc_rel | input | 1 | Base comes from the program counter |
| req_reg | input | 4 | Register index |
| req_reg_val | input | 32 | Current register value |
| req_base | input | 32 | Precomputed base address for mode 4 |
| req_size | input | 3 | Operand size code |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was illegal |
| rsp_addr | output | 32 | Access address |
| rsp_lane | output | 2 | Starting byte lane of a sub-word operand |
| rsp_wb_en | output | 1 | Register write-back enable |
| rsp_wb_reg | output | 4 | Register to write back |
| rsp_wb_val | output | 32 | Value to write back |

## Verification
The assertions assume that register values do not wrap across address zero by less than 12 bytes. They also assume the running offset never exceeds its counter width between two clears. The stimulus uses register values and bases well inside the address range, and it clears the offset before any run of repeated parts longer than a few transfers. Illegal mode, size and program-counter combinations are driven on purpose, and a legal access follows each one so that the effect on the offset shows in the next address.

// File: rtl/aeu_pkg.sv
package aeu_pkg;

  localparam int LEN_W = 4;

  typedef enum logic [2:0] {
    AM_DIRECT   = 3'd0,
    AM_INDIRECT = 3'd1,
    AM_POSTINC  = 3'd2,
    AM_PREDEC   = 3'd3,
    AM_BASED    = 3'd4
  } am_e;

  // Size code to byte count; zero marks an unsupported code.
  function automatic logic [LEN_W-1:0] size_to_len(input logic [2:0] code);
    logic [LEN_W-1:0] n;
    case (code)
      3'd0:    n = 4'd1;
      3'd1:    n = 4'd2;
      3'd2:    n = 4'd4;
      3'd3:    n = 4'd8;
      3'd4:    n = 4'd12;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/aeu_step.sv
module aeu_step
  import aeu_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int SP_IDX = 15
) (
  input  logic [2:0]       size_code,
  input  logic [REG_W-1:0] reg_idx,
  output logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] step,
  output logic             size_ok
);

  localparam logic [REG_W-1:0] SP_SEL = REG_W'(SP_IDX);

  logic sp_byte;

  always_comb begin
    len     = size_to_len(size_code);
    size_ok = (len != '0);
    // The stack pointer stays word aligned, so byte accesses step by two.
    sp_byte = (len == LEN_W'(1)) && (reg_idx == SP_SEL);
    step    = sp_byte ? LEN_W'(2) : len;
  end

endmodule

// File: rtl/aeu_addr_path.sv
module aeu_addr_path
  import aeu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFS_W = 6
) (
  input  logic [2:0]       mode,
  input  logic             pc_rel,
  input  logic [AW-1:0]    reg_val,
  input  logic [AW-1:0]    base,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] step,
  input  logic             size_ok,
  input  logic [OFS_W-1:0] ofs,
  output logic             err,
  output logic [AW-1:0]    addr,
  output logic [1:0]       lane,
  output logic             upd,
  output logic [AW-1:0]    wb_val,
  output logic             ofs_clear,
  output logic             ofs_adv
);

  logic [AW-1:0] step_x;
  logic [AW-1:0] ofs_x;
  logic          mode_ok;
  logic          updating;
  logic          direct_bad;

  always_comb begin
    step_x     = AW'(step);
    ofs_x      = AW'(ofs);
    mode_ok    = (mode <= 3'(AM_BASED));
    updating   = (mode == 3'(AM_POSTINC)) || (mode == 3'(AM_PREDEC));
    direct_bad = (mode == 3'(AM_DIRECT)) &&
                 ((len > LEN_W'(4)) || (ofs != '0));
    err        = !size_ok || !mode_ok || (updating && pc_rel) || direct_bad;
  end

  always_comb begin
    addr      = '0;
    wb_val    = '0;
    upd       = 1'b0;
    ofs_clear = 1'b0;
    ofs_adv   = 1'b0;
    if (!err) begin
      case (mode)
        3'(AM_DIRECT): begin
          ofs_adv = 1'b1;
        end
        3'(AM_INDIRECT): begin
          addr    = reg_val + ofs_x;
          ofs_adv = 1'b1;
        end
        3'(AM_POSTINC): begin
          addr      = reg_val;
          wb_val    = reg_val + step_x;
          upd       = 1'b1;
          ofs_clear = 1'b1;
        end
        3'(AM_PREDEC): begin
          addr      = reg_val - step_x;
          wb_val    = reg_val - step_x;
          upd       = 1'b1;
          ofs_clear = 1'b1;
        end
        3'(AM_BASED): begin
          addr    = base + ofs_x;
          ofs_adv = 1'b1;
        end
        default: begin
          addr = '0;
        end
      endcase
    end
  end

  // Sub-word operands occupy the low-order bytes of a 32-bit holder.
  always_comb begin
    if (err) lane = 2'd0;
    else if (len == LEN_W'(1)) lane = 2'd3;
    else if (len == LEN_W'(2)) lane = 2'd2;
    else lane = 2'd0;
  end

endmodule

// File: rtl/aeu_ofs_track.sv
module aeu_ofs_track
  import aeu_pkg::*;
#(
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             req_valid,
  input  logic             err,
  input  logic             ofs_clear,
  input  logic             ofs_adv,
  input  logic [LEN_W-1:0] len,
  output logic [OFS_W-1:0] ofs_eff
);

  logic [OFS_W-1:0] ofs_q;
  logic [OFS_W-1:0] ofs_d;
  logic             ofs_en;
  logic             take;

  always_comb begin
    ofs_eff = clr ? '0 : ofs_q;
    take    = req_valid && !err;
    ofs_en  = clr || take;
    ofs_d   = ofs_eff;
    if (take && ofs_clear)    ofs_d = '0;
    else if (take && ofs_adv) ofs_d = ofs_eff + OFS_W'(len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ofs_q <= '0;
    else if (ofs_en) ofs_q <= ofs_d;
  end

  assert_upd_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !err && ofs_clear) |=> (ofs_q == '0));

  assert_err_keeps_ofs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && err && !clr) |=> $stable(ofs_q));

  assert_clr_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(req_valid && !err && ofs_adv)) |=> (ofs_q == '0));

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !clr) |=> $stable(ofs_q));

endmodule

// File: rtl/ea_autoupdate.sv
module ea_autoupdate
  import aeu_pkg::*;
#(
  parameter int AW     = 32,
  parameter int REG_W  = 4,
  parameter int OFS_W  = 6,
  parameter int SP_IDX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_ofs,
  input  logic             req_valid,
  input  logic [2:0]       req_mode,
  input  logic             req_pc_rel,
  input  logic [REG_W-1:0] req_reg,
  input  logic [AW-1:0]    req_reg_val,
  input  logic [AW-1:0]    req_base,
  input  logic [2:0]       req_size,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [AW-1:0]    rsp_addr,
  output logic [1:0]       rsp_lane,
  output logic             rsp_wb_en,
  output logic [REG_W-1:0] rsp_wb_reg,
  output logic [AW-1:0]    rsp_wb_val
);

  localparam logic [AW-1:0] MAX_STEP = AW'(12);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta;
  logic rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] step;
  logic             size_ok;
  logic [OFS_W-1:0] ofs_eff;
  logic             err;
  logic [AW-1:0]    addr;
  logic [1:0]       lane;
  logic             upd;
  logic [AW-1:0]    wb_val;
  logic             ofs_clear;
  logic             ofs_adv;

  aeu_step #(.REG_W(REG_W), .SP_IDX(SP_IDX)) u_step (
    .size_code (req_size),
    .reg_idx   (req_reg),
    .len       (len),
    .step      (step),
    .size_ok   (size_ok)
  );

  aeu_addr_path #(.AW(AW), .OFS_W(OFS_W)) u_path (
    .mode      (req_mode),
    .pc_rel    (req_pc_rel),
    .reg_val   (req_reg_val),
    .base      (req_base),
    .len       (len),
    .step      (step),
    .size_ok   (size_ok),
    .ofs       (ofs_eff),
    .err       (err),
    .addr      (addr),
    .lane      (lane),
    .upd       (upd),
    .wb_val    (wb_val),
    .ofs_clear (ofs_clear),
    .ofs_adv   (ofs_adv)
  );

  aeu_ofs_track #(.OFS_W(OFS_W)) u_ofs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (clr_ofs),
    .req_valid (req_valid),
    .err       (err),
    .ofs_clear (ofs_clear),
    .ofs_adv   (ofs_adv),
    .len       (len),
    .ofs_eff   (ofs_eff)
  );

  // Response stage: control bits every cycle, payload on request only.
  logic             valid_d, err_d, wb_en_d;
  logic             pay_en;

  always_comb begin
    valid_d = req_valid;
    err_d   = req_valid && err;
    wb_en_d = req_valid && !err && upd;
    pay_en  = req_valid;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_wb_en <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_err   <= err_d;
      rsp_wb_en <= wb_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_addr   <= '0;
      rsp_lane   <= '0;
      rsp_wb_reg <= '0;
      rsp_wb_val <= '0;
    end else if (pay_en) begin
      rsp_addr   <= addr;
      rsp_lane   <= lane;
      rsp_wb_reg <= req_reg;
      rsp_wb_val <= wb_val;
    end
  end

  assert_wb_distance_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_wb_en |-> ((rsp_wb_val == rsp_addr) ||
                   (((rsp_wb_val - rsp_addr) <= MAX_STEP) && (rsp_wb_val != rsp_addr))));

  assert_pc_update_err_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_pc_rel && ((req_mode == 3'(AM_POSTINC)) || (req_mode == 3'(AM_PREDEC))))
      |=> (rsp_err && !rsp_wb_en));

  assert_err_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_err |-> (!rsp_wb_en && rsp_valid));

  assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid |=> rsp_valid);

  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |=> !rsp_valid);

  assert_direct_no_wb_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && (req_mode == 3'(AM_DIRECT))) |=> !rsp_wb_en);

endmodule

// File: tb/ea_autoupdate_test.sv
module ea_autoupdate_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_ofs;
  logic        req_valid;
  logic [2:0]  req_mode;
  logic        req_pc_rel;
  logic [3:0]  req_reg;
  logic [31:0] req_reg_val;
  logic [31:0] req_base;
  logic [2:0]  req_size;
  logic        rsp_valid, rsp_err, rsp_wb_en;
  logic [31:0] rsp_addr, rsp_wb_val;
  logic [1:0]  rsp_lane;
  logic [3:0]  rsp_wb_reg;

  always #10 clk = ~clk;

  ea_autoupdate uut (
    .clk(clk), .rst_n(rst_n), .clr_ofs(clr_ofs), .req_valid(req_valid),
    .req_mode(req_mode), .req_pc_rel(req_pc_rel), .req_reg(req_reg),
    .req_reg_val(req_reg_val), .req_base(req_base), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
    .rsp_lane(rsp_lane), .rsp_wb_en(rsp_wb_en), .rsp_wb_reg(rsp_wb_reg),
    .rsp_wb_val(rsp_wb_val)
  );

  typedef struct {
    bit          err;
    logic [31:0] addr;
    logic [1:0]  lane;
    bit          wb;
    logic [3:0]  wreg;
    logic [31:0] wval;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks   = 0;
  int   failures = 0;
  int   model_ofs = 0;

  task automatic fail_line(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    failures++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // Driver: applies one request and pushes the response the requirements predict.
  task automatic issue(input logic [2:0] mode, input bit pc, input logic [3:0] rg,
                       input logic [31:0] val, input logic [31:0] base,
                       input logic [2:0] size, input bit clr, input string tag);
    exp_t e;
    int   len, stp;
    bit   upd;
    @(negedge clk);
    req_valid = 1'b1; req_mode = mode; req_pc_rel = pc; req_reg = rg;
    req_reg_val = val; req_base = base; req_size = size; clr_ofs = clr;
    if (clr) model_ofs = 0;
    case (size)
      3'd0: len = 1; 3'd1: len = 2; 3'd2: len = 4; 3'd3: len = 8; 3'd4: len = 12;
      default: len = 0;
    endcase
    stp = (len == 1 && rg == 4'd15) ? 2 : len;
    upd = (mode == 3'd2 || mode == 3'd3);
    e.tag = tag; e.wb = 0; e.addr = 0; e.wval = 0; e.wreg = rg; e.lane = 0;
    e.err = (len == 0) || (mode > 3'd4) || (upd && pc) ||
            (mode == 3'd0 && (len > 4 || model_ofs != 0));
    if (!e.err) begin
      e.lane = (len == 1) ? 2'd3 : (len == 2) ? 2'd2 : 2'd0;
      case (mode)
        3'd0: model_ofs += len;
        3'd1: begin e.addr = val + model_ofs; model_ofs += len; end
        3'd2: begin e.addr = val; e.wb = 1; e.wval = val + stp; model_ofs = 0; end
        3'd3: begin e.addr = val - stp; e.wb = 1; e.wval = val - stp; model_ofs = 0; end
        default: begin e.addr = base + model_ofs; model_ofs += len; end
      endcase
    end
    exp_q.push_back(e);
  endtask

  task automatic idle_only(input bit clr);
    @(negedge clk);
    req_valid = 1'b0; clr_ofs = clr;
    if (clr) model_ofs = 0;
  endtask

  // R11: no response in a cycle that follows no request.
  task automatic idle_check;
    idle_only(0);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) fail_line("R11", "rsp_valid idle", 32'(rsp_valid), 32'd0);
  endtask

  // Monitor: pops and compares each response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        fail_line("R11", "unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        bit bad;
        e = exp_q.pop_front();
        bad = (rsp_err !== e.err) || (rsp_wb_en !== e.wb);
        if (!e.err) begin
          bad |= (rsp_addr !== e.addr) || (rsp_lane !== e.lane);
          if (e.wb) bad |= (rsp_wb_val !== e.wval) || (rsp_wb_reg !== e.wreg);
        end
        if (bad) begin
          failures++;
          $display("FAIL %s actual err=%0b addr=%h lane=%0d wb=%0b reg=%0d val=%h expected err=%0b addr=%h lane=%0d wb=%0b reg=%0d val=%h",
                   e.tag, rsp_err, rsp_addr, rsp_lane, rsp_wb_en, rsp_wb_reg, rsp_wb_val,
                   e.err, e.addr, e.lane, e.wb, e.wreg, e.wval);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_ofs = 1'b0; req_valid = 1'b0; req_mode = 3'd0;
    req_pc_rel = 1'b0; req_reg = 4'd0; req_reg_val = '0; req_base = '0; req_size = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({rsp_valid, rsp_err, rsp_wb_en} !== 3'b000)
      fail_line("R1", "reset outputs", 32'({rsp_valid, rsp_err, rsp_wb_en}), 32'd0);

    // R5 repeated parts at a fixed address, then a base-mode part
    issue(3'd1, 0, 4'd9,  32'h0000_1000, 32'h0, 3'd2, 1, "R5");
    issue(3'd1, 0, 4'd9,  32'h0000_1000, 32'h0, 3'd2, 0, "R5");
    issue(3'd4, 0, 4'd0,  32'h0, 32'h0000_2000, 3'd3, 0, "R5");
    // R10 clear in the same cycle as a request
    issue(3'd4, 1, 4'd0,  32'h0, 32'h0000_2000, 3'd4, 1, "R10");
    idle_only(1);
    issue(3'd4, 0, 4'd0,  32'h0, 32'h0000_2400, 3'd2, 0, "R10");
    // R4 postincrement clears offset; following indirect shows zero offset
    issue(3'd2, 0, 4'd9,  32'h0000_3000, 32'h0, 3'd3, 0, "R4");
    issue(3'd1, 0, 4'd9,  32'h0000_3008, 32'h0, 3'd2, 0, "R4");
    // R3 predecrement 12 bytes
    issue(3'd3, 0, 4'd10, 32'h0000_4000, 32'h0, 3'd4, 0, "R3");
    // R2 stack pointer byte steps, non-stack byte step, word step
    issue(3'd3, 0, 4'd15, 32'h0000_5000, 32'h0, 3'd0, 0, "R2");
    issue(3'd2, 0, 4'd15, 32'h0000_5000, 32'h0, 3'd0, 0, "R2");
    issue(3'd2, 0, 4'd14, 32'h0000_5000, 32'h0, 3'd0, 0, "R2");
    issue(3'd2, 0, 4'd15, 32'h0000_6000, 32'h0, 3'd1, 0, "R8");
    idle_check();
    // R6 program-counter base with updating modes, offset untouched afterwards
    issue(3'd1, 0, 4'd8,  32'h0000_7000, 32'h0, 3'd2, 1, "R5");
    issue(3'd2, 1, 4'd8,  32'h0000_7000, 32'h0, 3'd2, 0, "R6");
    issue(3'd3, 1, 4'd8,  32'h0000_7000, 32'h0, 3'd2, 0, "R6");
    issue(3'd1, 0, 4'd8,  32'h0000_7000, 32'h0, 3'd2, 0, "R9");
    // R7 register direct: first ok, second illegal, wide illegal
    issue(3'd0, 0, 4'd3,  32'h1234_5678, 32'h0, 3'd1, 1, "R7");
    issue(3'd0, 0, 4'd3,  32'h1234_5678, 32'h0, 3'd1, 0, "R7");
    issue(3'd0, 0, 4'd3,  32'h1234_5678, 32'h0, 3'd3, 1, "R7");
    issue(3'd0, 0, 4'd3,  32'h1234_5678, 32'h0, 3'd0, 1, "R8");
    // R9 illegal codes leave offset alone
    issue(3'd1, 0, 4'd1,  32'h0000_8000, 32'h0, 3'd2, 1, "R5");
    issue(3'd5, 0, 4'd1,  32'h0000_8000, 32'h0, 3'd2, 0, "R9");
    issue(3'd1, 0, 4'd1,  32'h0000_8000, 32'h0, 3'd6, 0, "R9");
    issue(3'd4, 0, 4'd1,  32'h0, 32'h0000_9000, 3'd2, 0, "R9");
    idle_check();
    repeat (2) idle_only(0);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) fail_line("R11", "missing responses", 32'(exp_q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule